// File: doc/BRIEF.md
# Serial Stereo Audio Receiver

This block receives a two-channel audio stream over a standard I2S link in which it is the slave. It runs directly on the incoming bit clock. On each rising edge it samples the frame-sync and serial-data lines. A change in the frame-sync level opens a new channel word. The level sets the channel: low for left, high for right. The first data bit after the change is the most significant one. Each channel occupies a fixed 32-slot window. Only the first 24 data bits of a window are kept as a two's complement sample. Longer words therefore lose their low bits. Shorter words that the sender pads with zeros arrive unchanged.

A completed left sample is held internally until the matching right sample finishes. The left and right output registers are then loaded together, and a one-cycle strobe marks the new pair. A frame-sync change that arrives before a word is complete restarts the slot count and throws the partial word away. Crossing into another clock, filtering and clock checking are handled outside this block.

Top module: `i2s_stereo_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, both sample outputs are zero and the pair strobe is low.
- R2: A word received while frame sync is low is a left sample. A word received while it is high is a right sample. The strobe fires only for the right channel.
- R3: The bit sampled on the same rising edge at which the frame-sync change is first seen is ignored. The most significant data bit is sampled on the next rising edge.
- R4: With a 32-bit word, the output holds bits 31..8 of the word and drops the lowest 8 bits. The slot counter never goes beyond 32.
- R5: A 16-bit word padded with 16 low zeros appears unchanged in the top 16 bits of the 24-bit output, with zeros below.
- R6: The strobe is high for exactly one cycle. It follows the rising edge that samples the 24th data bit of a right word. On that same edge both outputs load their new values.
- R7: A frame-sync change before 24 data bits of a word have arrived discards that partial word. A discarded left word leaves the last complete left sample in use for the next pair.
- R8: Between strobes both sample outputs keep their values.
- R9: After reset, nothing is captured until the first frame-sync change. A right word cut off before its 24th data bit produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_sync | input | 1 | Channel select: low = left, high = right |
| ser_data | input | 1 | Serial audio data, MSB first |
| left_out | output | 24 | Last complete left sample, two's complement |
| right_out | output | 24 | Last complete right sample, two's complement |
| pair_valid | output | 1 | One-cycle strobe when both outputs load |

## Verification
The hardest situations to reach from the pins are words that end early. These are a left word cut short just before a full right word, and right words cut off at exactly 23 or 24 data bits. The stimulus drives each channel window with a chosen slot count, so a frame-sync edge can land at any slot. The bench then checks whether a strobe appears and which left value is paired with the right sample. Before the first frame-sync edge after reset, and in each window's first slot, the data line is held at one. This shows that those bits never reach the outputs.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    localparam int unsigned DEF_SAMPLE_W = 24;
    localparam int unsigned DEF_SLOTS    = 32;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    function automatic int unsigned cnt_width(input int unsigned slots);
        return $clog2(slots + 1);
    endfunction

endpackage

// File: rtl/i2s_fs_track.sv
module i2s_fs_track
    import i2s_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fs,
    output logic  fs_change,
    output chan_e fs_chan
);
    logic fs_q;

    always_ff @(posedge clk) begin
        if (rst) fs_q <= 1'b0;
        else     fs_q <= fs;
    end

    assign fs_change = fs ^ fs_q;
    assign fs_chan   = chan_e'(fs);
endmodule

// File: rtl/i2s_slot_ctr.sv
module i2s_slot_ctr #(
    parameter int unsigned SLOTS    = 32,
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned CNT_W    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt,
    output logic             take,
    output logic             last
);
    localparam logic [CNT_W-1:0] LIM    = CNT_W'(SLOTS);
    localparam logic [CNT_W-1:0] DLIM   = CNT_W'(SAMPLE_W);
    localparam logic [CNT_W-1:0] DFINAL = CNT_W'(SAMPLE_W - 1);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (restart) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (armed && cnt < LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign take = armed && !restart && (cnt < DLIM);
    assign last = take && (cnt == DFINAL);
endmodule

// File: rtl/i2s_word_shift.sv
module i2s_word_shift #(
    parameter int unsigned SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                take,
    input  logic                din,
    output logic [SAMPLE_W-1:0] word_next
);
    generate
        if (SAMPLE_W > 1) begin : g_multi
            logic [SAMPLE_W-2:0] sh;
            always_ff @(posedge clk) begin
                if (rst || clear) sh <= '0;
                else if (take)    sh <= {sh[SAMPLE_W-3:0], din};
            end
            assign word_next = {sh, din};
        end else begin : g_single
            assign word_next = din;
        end
    endgenerate
endmodule

// File: rtl/i2s_stereo_rx.sv
module i2s_stereo_rx
    import i2s_rx_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned SLOTS    = DEF_SLOTS
) (
    input  logic                bit_clk,
    input  logic                rst,
    input  logic                frame_sync,
    input  logic                ser_data,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                pair_valid
);
    localparam int unsigned CNT_W = cnt_width(SLOTS);

    logic                fs_change;
    chan_e               fs_chan;
    chan_e               chan_q;
    logic [CNT_W-1:0]    slot_cnt;
    logic                take;
    logic                last;
    logic [SAMPLE_W-1:0] word_next;
    logic [SAMPLE_W-1:0] left_hold;

    i2s_fs_track u_fs (
        .clk       (bit_clk),
        .rst       (rst),
        .fs        (frame_sync),
        .fs_change (fs_change),
        .fs_chan   (fs_chan)
    );

    i2s_slot_ctr #(
        .SLOTS    (SLOTS),
        .SAMPLE_W (SAMPLE_W),
        .CNT_W    (CNT_W)
    ) u_ctr (
        .clk     (bit_clk),
        .rst     (rst),
        .restart (fs_change),
        .cnt     (slot_cnt),
        .take    (take),
        .last    (last)
    );

    i2s_word_shift #(
        .SAMPLE_W (SAMPLE_W)
    ) u_shift (
        .clk       (bit_clk),
        .rst       (rst),
        .clear     (fs_change),
        .take      (take),
        .din       (ser_data),
        .word_next (word_next)
    );

    always_ff @(posedge bit_clk) begin
        if (rst) begin
            chan_q     <= CH_LEFT;
            left_hold  <= '0;
            left_out   <= '0;
            right_out  <= '0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (fs_change) chan_q <= fs_chan;
            if (last) begin
                if (chan_q == CH_LEFT) begin
                    left_hold <= word_next;
                end else begin
                    left_out   <= left_hold;
                    right_out  <= word_next;
                    pair_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/i2s_rx_checker.sv
module i2s_rx_checker #(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned SLOTS    = 32,
    parameter int unsigned CNT_W    = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                lrck,
    input logic                pair_valid,
    input logic [SAMPLE_W-1:0] left_out,
    input logic [SAMPLE_W-1:0] right_out,
    input logic [CNT_W-1:0]    slot_cnt,
    input logic                cur_chan
);
    logic fs_prev;
    always_ff @(posedge clk) begin
        if (rst) fs_prev <= 1'b0;
        else     fs_prev <= lrck;
    end

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pair_valid |=> !pair_valid);

    a_r8_hold_left: assert property (@(posedge clk) disable iff (rst)
        !pair_valid |-> $stable(left_out));

    a_r8_hold_right: assert property (@(posedge clk) disable iff (rst)
        !pair_valid |-> $stable(right_out));

    a_r7_restart_quiet: assert property (@(posedge clk) disable iff (rst)
        (lrck != fs_prev) |=> !pair_valid);

    a_r2_right_only: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> cur_chan);

    a_r4_slot_bound: assert property (@(posedge clk) disable iff (rst)
        slot_cnt <= CNT_W'(SLOTS));
endmodule

bind i2s_stereo_rx i2s_rx_checker #(
    .SAMPLE_W (SAMPLE_W),
    .SLOTS    (SLOTS),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (bit_clk),
    .rst        (rst),
    .lrck       (frame_sync),
    .pair_valid (pair_valid),
    .left_out   (left_out),
    .right_out  (right_out),
    .slot_cnt   (slot_cnt),
    .cur_chan   (chan_q)
);

// File: tb/test_i2s_stereo_rx.sv
`timescale 1ns/1ps
module test_i2s_stereo_rx;
    localparam int NV = 6;
    localparam logic [31:0] VL [NV] = '{32'h12345678, 32'h7FFFFFFF, 32'h00000000,
                                        32'h80010000, 32'h000001FF, 32'hA5A5A5A5};
    localparam logic [31:0] VR [NV] = '{32'h9ABCDEF0, 32'h80000000, 32'hFFFFFFFF,
                                        32'h7FFE0000, 32'h00000100, 32'h5A5A5A5A};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fs  = 1'b0;
    logic        sd  = 1'b0;
    logic [23:0] left_out, right_out;
    logic        pair_valid;

    int checks = 0;
    int fails  = 0;
    int vcount = 0;
    logic [23:0] got_l = '0, got_r = '0;
    bit done = 0;

    always #10 clk = ~clk;

    i2s_stereo_rx i_i2s_stereo_rx (
        .bit_clk    (clk),
        .rst        (rst),
        .frame_sync (fs),
        .ser_data   (sd),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid)
    );

    always @(negedge clk) begin
        if (pair_valid) begin
            vcount++;
            got_l = left_out;
            got_r = right_out;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // slot 0 carries a junk one; slots 1.. carry bits 31 downward
    task automatic send_chan(input logic ch, input logic [31:0] w, input int n);
        for (int s = 0; s < n; s++) begin
            @(negedge clk);
            fs = ch;
            sd = (s == 0) ? 1'b1 : w[32-s];
        end
    endtask

    initial begin
        int v0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(left_out == 24'h0,  "R1 left",  {8'h0, left_out},  0);
        chk(right_out == 24'h0, "R1 right", {8'h0, right_out}, 0);
        chk(pair_valid == 1'b0, "R1 valid", {31'h0, pair_valid}, 0);

        // R9: no frame-sync change yet, data held high: nothing captured
        for (int i = 0; i < 40; i++) begin @(negedge clk); fs = 1'b0; sd = 1'b1; end
        chk(vcount == 0, "R9 idle before first edge", vcount, 0);
        send_chan(1'b1, 32'hFFFFFFFF, 8);
        chk(vcount == 0, "R9 short right", vcount, 0);

        // table of pairs: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            v0 = vcount;
            send_chan(1'b0, VL[i], 32);
            send_chan(1'b1, VR[i], 32);
            chk(vcount == v0 + 1, "R6 one strobe per pair", vcount - v0, 1);
            chk(got_l == VL[i][31:8], "R2/R4/R5 left", {8'h0, got_l}, {8'h0, VL[i][31:8]});
            chk(got_r == VR[i][31:8], "R2/R4/R5 right", {8'h0, got_r}, {8'h0, VR[i][31:8]});
        end

        // R7: left cut short, earlier complete left stays paired
        v0 = vcount;
        send_chan(1'b0, 32'hCAFEBA00, 10);
        send_chan(1'b1, 32'h0BADF000, 32);
        chk(vcount == v0 + 1, "R7 strobe count", vcount - v0, 1);
        chk(got_l == 24'hA5A5A5, "R7 partial left discarded", {8'h0, got_l}, 32'hA5A5A5);
        chk(got_r == 24'h0BADF0, "R7 right", {8'h0, got_r}, 32'h0BADF0);

        // R9/R8: right cut at 11 bits -> no strobe, outputs held
        v0 = vcount;
        send_chan(1'b0, 32'h11223300, 32);
        send_chan(1'b1, 32'h44556600, 12);
        chk(vcount == v0, "R9 partial right no strobe", vcount - v0, 0);
        chk(left_out == 24'hA5A5A5, "R8 left held", {8'h0, left_out}, 32'hA5A5A5);
        chk(right_out == 24'h0BADF0, "R8 right held", {8'h0, right_out}, 32'h0BADF0);

        // R6 boundary: right window of exactly 24 data bits
        v0 = vcount;
        send_chan(1'b0, 32'h77889900, 32);
        send_chan(1'b1, 32'hAABBCC00, 25);
        send_chan(1'b0, 32'h0, 4);
        chk(vcount == v0 + 1, "R6 24-bit window strobes", vcount - v0, 1);
        chk(got_l == 24'h778899, "R6 left", {8'h0, got_l}, 32'h778899);
        chk(got_r == 24'hAABBCC, "R6 right", {8'h0, got_r}, 32'hAABBCC);

        // R9 boundary: 23 data bits only
        v0 = vcount;
        send_chan(1'b0, 32'h01020300, 32);
        send_chan(1'b1, 32'h04050600, 24);
        send_chan(1'b0, 32'h0, 4);
        chk(vcount == v0, "R9 23-bit window no strobe", vcount - v0, 0);
        chk(right_out == 24'hAABBCC, "R8 right held after cut", {8'h0, right_out}, 32'hAABBCC);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule